// File: doc/BRIEF.md
# Repeated String Copy Engine

This block is a sequencer that copies elements of 1, 2, 4 or 8 bytes from a source pointer to a destination pointer. It uses a single memory port with a request/ready handshake. A start pulse loads both pointers, a count, the element size, a direction flag, an address-width mode and a repeat enable. It also loads a lock-prefix indicator, an alignment-check enable and the current privilege level. After each element, both pointers step by the element size. In repeat mode the count is decremented and the run continues until the count reaches zero. Without repeat, exactly one element moves.

Addresses are flat and linear. The pointers and the count wrap inside the selected width (16, 32 or 64 bits). Three fault rules can end a run, each with a fault code:
- a lock prefix;
- an 8-byte element outside 64-bit mode;
- an alignment violation at user privilege.

When a fault ends a run, the returned pointers and count reflect only the elements that completed.

Top module: `strcopy_seq`

## Requirements
- R1: Each element is read from the source address and written unchanged to the destination address. The element size code 0,1,2,3 selects 1,2,4,8 bytes. Data occupies the low bytes of the 64-bit data buses in little-endian order, and the low `1<<size` byte enables are set.
- R2: After each element completes, both pointers increase by the element size when the direction flag is 0, and decrease by it when the flag is 1.
- R3: With repeat set, the number of elements copied equals the count, and the count drops by one after each element's write. A masked count of zero ends the run at once, with no memory access and no change to pointers or count.
- R4: With repeat clear, exactly one element is copied and the count output keeps its loaded value.
- R5: Mode code 0 selects 16-bit width, 1 selects 32-bit width, and 2 or 3 selects 64-bit width. Pointer and count arithmetic wraps inside that width. In 16-bit mode, bits 63:16 are kept unchanged. In 32-bit mode, bits 63:32 become zero. The memory address is the pointer masked to the width.
- R6: Size code 3 with a mode code of 0 or 1 ends the run with fault code 1 and no memory access.
- R7: A lock indicator ends the run with fault code 1 before any memory access, whatever the other inputs are.
- R8: When alignment checking is on, the privilege is 3, and either pointer is not a multiple of the element size, the run stops with fault code 2 before that element's read. Without all three conditions, no alignment fault is raised.
- R9: A memory request holds its address and write flag steady until ready is seen.
- R10: `done` is high for one cycle, on the edge that ends a run, and `busy` is low in that cycle. `fault` is high with `done` exactly when the fault code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse, taken when idle |
| src_in | input | 64 | Initial source pointer |
| dst_in | input | 64 | Initial destination pointer |
| cnt_in | input | 64 | Initial element count |
| size_in | input | 2 | Element size code |
| dir_in | input | 1 | 0 ascending, 1 descending |
| mode_in | input | 2 | Address width code |
| rep_in | input | 1 | Repeat enable |
| lock_in | input | 1 | Lock prefix present |
| acheck_in | input | 1 | Alignment checking enabled |
| cpl_in | input | 2 | Current privilege level |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 64 | Byte address |
| mem_be | output | 8 | Byte enables |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data |
| mem_rdy | input | 1 | Transfer accepted |
| src_out | output | 64 | Current source pointer |
| dst_out | output | 64 | Current destination pointer |
| cnt_out | output | 64 | Current count |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished pulse |
| fault | output | 1 | Run ended by a fault |
| fault_code | output | 2 | 0 none, 1 invalid opcode, 2 alignment |

## Verification
Two events can coincide on one edge: the write of the final element completes, and the count steps to zero. On that edge the pointers, the count and `done` must all update together. Runs of up to three elements are started with the ready line stalled in a pseudo-random pattern, so the final write lands on varied cycles. The outputs captured at `done` are compared with an arithmetic model of pointers, count and byte-level memory contents. A second coincidence is wraparound during the same step: pointer sets placed just below the top of the 16-, 32- and 64-bit ranges make a step cross the boundary. The bench judges the result against the width-masking rules.

// File: rtl/strcopy_seq.sv
module strcopy_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] src_in,
  input  logic [63:0] dst_in,
  input  logic [63:0] cnt_in,
  input  logic [1:0]  size_in,
  input  logic        dir_in,
  input  logic [1:0]  mode_in,
  input  logic        rep_in,
  input  logic        lock_in,
  input  logic        acheck_in,
  input  logic [1:0]  cpl_in,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [7:0]  mem_be,
  output logic [63:0] mem_wdata,
  input  logic [63:0] mem_rdata,
  input  logic        mem_rdy,
  output logic [63:0] src_out,
  output logic [63:0] dst_out,
  output logic [63:0] cnt_out,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic [1:0]  fault_code
);

  localparam logic [1:0] CODE_NONE  = 2'd0;
  localparam logic [1:0] CODE_UD    = 2'd1;
  localparam logic [1:0] CODE_ALIGN = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  function automatic logic [63:0] width_mask(input logic [1:0] md);
    case (md)
      2'd0:    width_mask = 64'h0000_0000_0000_FFFF;
      2'd1:    width_mask = 64'h0000_0000_FFFF_FFFF;
      default: width_mask = '1;
    endcase
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] old_v, input logic [63:0] new_v,
                                        input logic [1:0] md);
    case (md)
      2'd0:    merge = {old_v[63:16], new_v[15:0]};
      2'd1:    merge = {32'd0, new_v[31:0]};
      default: merge = new_v;
    endcase
  endfunction

  st_t         st;
  logic [63:0] src_q, dst_q, cnt_q, buf_q;
  logic [1:0]  sz_q, md_q, cpl_q, code_q;
  logic        dir_q, rep_q, ac_q, done_q;

  wire [63:0] step   = 64'd1 << sz_q;
  wire [63:0] msk    = width_mask(md_q);
  wire [63:0] dmask  = (64'd1 << (64'd8 << sz_q)) - 64'd1;
  wire [63:0] src_nx = merge(src_q, dir_q ? src_q - step : src_q + step, md_q);
  wire [63:0] dst_nx = merge(dst_q, dir_q ? dst_q - step : dst_q + step, md_q);
  wire [63:0] cnt_nx = merge(cnt_q, cnt_q - 64'd1, md_q);
  wire        misal  = ac_q && (cpl_q == 2'd3) && (((src_q | dst_q) & (step - 64'd1)) != 64'd0);
  wire [63:0] cnt_start = cnt_in & width_mask(mode_in);
  wire [8:0]  be_w   = (9'd1 << step[3:0]) - 9'd1;

  assign mem_req    = (st == S_RD && !misal) || st == S_WR;
  assign mem_we     = (st == S_WR);
  assign mem_addr   = (st == S_WR ? dst_q : src_q) & msk;
  assign mem_be     = be_w[7:0];
  assign mem_wdata  = buf_q;
  assign src_out    = src_q;
  assign dst_out    = dst_q;
  assign cnt_out    = cnt_q;
  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign fault      = done_q && (code_q != CODE_NONE);
  assign fault_code = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src_q <= '0; dst_q <= '0; cnt_q <= '0; buf_q <= '0;
      sz_q <= '0; md_q <= '0; cpl_q <= '0; code_q <= CODE_NONE;
      dir_q <= 1'b0; rep_q <= 1'b0; ac_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          src_q <= src_in; dst_q <= dst_in; cnt_q <= cnt_in;
          sz_q <= size_in; md_q <= mode_in; cpl_q <= cpl_in;
          dir_q <= dir_in; rep_q <= rep_in; ac_q <= acheck_in;
          code_q <= CODE_NONE;
          if (lock_in || (size_in == 2'd3 && mode_in < 2'd2)) begin
            code_q <= CODE_UD;
            done_q <= 1'b1;
          end else if (rep_in && cnt_start == 64'd0) begin
            done_q <= 1'b1;
          end else begin
            st <= S_RD;
          end
        end
        S_RD: begin
          if (misal) begin
            code_q <= CODE_ALIGN;
            done_q <= 1'b1;
            st <= S_IDLE;
          end else if (mem_rdy) begin
            buf_q <= mem_rdata & dmask;
            st <= S_WR;
          end
        end
        S_WR: if (mem_rdy) begin
          src_q <= src_nx;
          dst_q <= dst_nx;
          if (rep_q) cnt_q <= cnt_nx;
          if (!rep_q || (cnt_nx & msk) == 64'd0) begin
            done_q <= 1'b1;
            st <= S_IDLE;
          end else begin
            st <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_be_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $countones(mem_be) == (1 << sz_q));

  assert_no_partial_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(mem_req && mem_we && mem_rdy) |=>
      $stable(cnt_out) && $stable(src_out) && $stable(dst_out));

  assert_bad_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !lock_in && size_in == 2'd3 && mode_in < 2'd2 |=>
      fault && fault_code == CODE_UD && !mem_req);

  assert_lock_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && lock_in |=> done && fault_code == CODE_UD && !mem_req);

  assert_aligned_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && ac_q && cpl_q == 2'd3 |-> (mem_addr & (step - 64'd1)) == 64'd0);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/sim_strcopy_seq.sv
module sim_strcopy_seq;
  localparam int PER = 10;

  logic clk = 0, rst_n = 0, start = 0;
  logic [63:0] src_in = 0, dst_in = 0, cnt_in = 0;
  logic [1:0]  size_in = 0, mode_in = 0, cpl_in = 0;
  logic dir_in = 0, rep_in = 0, lock_in = 0, acheck_in = 0;
  logic mem_req, mem_we, mem_rdy = 0;
  logic [63:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [7:0]  mem_be;
  logic [63:0] src_out, dst_out, cnt_out;
  logic busy, done, fault;
  logic [1:0] fault_code;

  int total = 0, bad = 0, acc = 0, hs_bad = 0;
  logic [7:0] mem [256];
  logic [7:0] em [256];
  logic [7:0] lfsr = 8'h5B;
  logic prev_wait = 0, prev_we = 0;
  logic [63:0] prev_addr = 0;

  strcopy_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .src_in(src_in), .dst_in(dst_in),
    .cnt_in(cnt_in), .size_in(size_in), .dir_in(dir_in), .mode_in(mode_in), .rep_in(rep_in),
    .lock_in(lock_in), .acheck_in(acheck_in), .cpl_in(cpl_in), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .src_out(src_out), .dst_out(dst_out),
    .cnt_out(cnt_out), .busy(busy), .done(done), .fault(fault), .fault_code(fault_code));

  always #(PER/2) clk = ~clk;

  always @(negedge clk) begin
    if (prev_wait && (!mem_req || mem_addr != prev_addr || mem_we != prev_we)) hs_bad++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_rdy = lfsr[0] | lfsr[1];
    if (mem_req && mem_rdy) begin
      acc++;
      if (mem_we) begin
        for (int i = 0; i < 8; i++) if (mem_be[i]) mem[8'(mem_addr + 64'(i))] = mem_wdata[8*i +: 8];
      end else begin
        mem_rdata = '0;
        for (int i = 0; i < 8; i++) if (mem_be[i]) mem_rdata[8*i +: 8] = mem[8'(mem_addr + 64'(i))];
      end
    end
    prev_wait = mem_req && !mem_rdy;
    prev_addr = mem_addr;
    prev_we   = mem_we;
  end

  function automatic logic [63:0] wmask(input logic [1:0] md);
    return md == 2'd0 ? 64'hFFFF : md == 2'd1 ? 64'hFFFF_FFFF : '1;
  endfunction

  function automatic logic [63:0] wrapv(input logic [63:0] o, input logic [63:0] n, input logic [1:0] md);
    if (md == 2'd0) return (o & ~64'hFFFF) | (n & 64'hFFFF);
    if (md == 2'd1) return n & 64'hFFFF_FFFF;
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] s0, input logic [63:0] d0, input logic [63:0] c0,
                     input logic [1:0] sz, input logic dr, input logic [1:0] md, input logic rp,
                     input logic lk, input logic ac, input logic [1:0] cp,
                     input string ptag, input string ctag);
    logic [63:0] m, s, d, c, n, st;
    logic [1:0] code;
    logic [7:0] tmp [8];
    int nb, copied, wd, diff;
    nb = 1 << sz;
    m = wmask(md);
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 11 + int'(sz) * 5 + int'(md));
      em[i] = mem[i];
    end
    s = s0; d = d0; c = c0; code = 0; copied = 0;
    st = 64'd1 << sz;
    if (lk || (sz == 2'd3 && md < 2'd2)) code = 1;
    else begin
      n = rp ? (c0 & m) : 64'd1;
      while (n != 0) begin
        if (ac && cp == 2'd3 && ((s | d) & (st - 1)) != 0) begin code = 2; break; end
        for (int i = 0; i < nb; i++) tmp[i] = em[8'((s & m) + 64'(i))];
        for (int i = 0; i < nb; i++) em[8'((d & m) + 64'(i))] = tmp[i];
        s = wrapv(s, dr ? s - st : s + st, md);
        d = wrapv(d, dr ? d - st : d + st, md);
        if (rp) c = wrapv(c, c - 1, md);
        copied++;
        n--;
      end
    end
    src_in = s0; dst_in = d0; cnt_in = c0; size_in = sz; dir_in = dr; mode_in = md;
    rep_in = rp; lock_in = lk; acheck_in = ac; cpl_in = cp;
    acc = 0;
    start = 1;
    @(negedge clk);
    start = 0;
    wd = 0;
    while (!done && wd < 2000) begin @(negedge clk); wd++; end
    chk(done == 1'b1, "R10", "done seen", 64'(done), 64'd1);
    chk(busy == 1'b0 && fault == (code != 0), "R10", "busy/fault at done",
        {62'd0, busy, fault}, {63'd0, code != 0});
    chk(src_out == s, ptag, "src", src_out, s);
    chk(dst_out == d, ptag, "dst", dst_out, d);
    chk(cnt_out == c, rp ? "R3" : "R4", "count", cnt_out, c);
    chk(fault_code == code, ctag, "fault code", 64'(fault_code), 64'(code));
    chk(acc == 2 * copied, "R3", "access count", 64'(acc), 64'(2 * copied));
    diff = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== em[i]) diff++;
    chk(diff == 0, "R1", "memory bytes differing", 64'(diff), 64'd0);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", 64'(done), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && fault_code == 0 && mem_req == 0, "R10", "reset state",
        {60'd0, busy, done, fault_code}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    for (int sz = 0; sz < 4; sz++)
      for (int dr = 0; dr < 2; dr++)
        for (int md = 0; md < 3; md++)
          for (int rp = 0; rp < 2; rp++)
            for (int wr = 0; wr < 2; wr++) begin
              logic [63:0] m, s0, d0, c0;
              m = wmask(2'(md));
              if (wr == 1) begin
                s0 = (64'hA5A5_5A5A_C3C3_0000 & ~m) | ((dr ? 64'h8 : m - 64'h7) & m);
                d0 = (64'h1234_5678_9ABC_0000 & ~m) | ((dr ? 64'h48 : m - 64'h47) & m);
              end else begin
                s0 = (64'h0F0F_0000_7000_0000 & ~m) | 64'h20;
                d0 = (64'h00FF_0000_0300_0000 & ~m) | 64'h90;
              end
              c0 = (64'hDEAD_BEEF_0000_0000 & ~m) | 64'd3;
              run(s0, d0, c0, 2'(sz), dr[0], 2'(md), rp[0], 1'b0, 1'b0, 2'd0,
                  wr == 1 ? "R5" : "R2", (sz == 3 && md < 2) ? "R6" : "R1");
            end
    run(64'h40, 64'h80, 64'd2, 2'd1, 1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 2'd0, "R7", "R7");
    run(64'h40, 64'h80, 64'd2, 2'd3, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 2'd0, "R7", "R7");
    run(64'h40, 64'h80, 64'hFFFF_0000, 2'd2, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 2'd0, "R3", "R3");
    run(64'h40, 64'h81, 64'd3, 2'd1, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 2'd3, "R8", "R8");
    run(64'h42, 64'h80, 64'd3, 2'd2, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 2'd3, "R8", "R8");
    run(64'h41, 64'h83, 64'd2, 2'd2, 1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 2'd0, "R8", "R8");
    run(64'h41, 64'h83, 64'd2, 2'd2, 1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 2'd3, "R8", "R8");
    run(64'h40, 64'h88, 64'd3, 2'd3, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 2'd3, "R8", "R8");
    chk(hs_bad == 0, "R9", "request changed while waiting", 64'(hs_bad), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PER * 200000);
    total++; bad++;
    $display("FAIL R10 watchdog expired: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule